// File: doc/BRIEF.md
# Cascadable Self-Test Sequencer

This block sequences a self-test in which test currents are switched onto the cell sense inputs one at a time, so that each cell pair appears overcharged on purpose and the overcharge path can be confirmed. The test is paced by a slow external test clock of about 10 Hz, with each high and low phase lasting at least 50 ms. A system clock samples that test clock, together with an active-low test-start input and an "active" input from the neighbouring device. The block counts test clocks to choose which cell current is on and which shortened detection delay the overcharge timer should use.

Identical devices sit in a daisy chain. After its own eight clocks, a device hands the reset and the clock on to the next device. It also relays that device's active flag back down with one test clock of delay per stage, so a monitor at the bottom of the chain can tell which device is under test. Every input passes through a synchronizer before use. Each output is a register driven from the synchronized inputs.

Top module: `stseq_top`

## Requirements
- R1: While the synchronized test-start input is high, or while `rst_n` is low, the outputs hold their idle values: `resetOut`=1, `clkOut`=1, `activeOut`=0, `cellCurEn`=0 and `delaySel`=2'b00. When the test-start pin goes high during a test, all outputs return to these values.
- R2: During a test, `resetOut` stays high up to and including the high phase of the 8th test clock. It goes low on the falling edge of that clock.
- R3: `clkOut` goes low when the test starts and stays low through the first eight test clocks. From the 9th clock on, it follows the test clock level.
- R4: `activeOut` goes high at the 1st test-clock rise and stays high through the 8th clock, whatever `activeIn` does. It goes low on the fall of the 8th clock.
- R5: From the 9th clock on, `activeOut` goes high only at a test-clock rise that finds `activeIn` high. It goes low as soon as `activeIn` is low. A high `activeIn` seen between rises does not set it.
- R6: `cellCurEn` is one-hot or zero. Bit k-1 is high only during the high phase of test clock k, for k = 1..5. Bit 0 is the pull-down on the second sense input, bit 1 the pull-down on the third, bit 2 the pull-up on the third, bit 3 the pull-up on the fourth and bit 4 the pull-up on the fifth.
- R7: The `delaySel` codes are 2'b00 for the normal delay, 2'b01 for the 8 ms fast delay and 2'b10 for the 32 ms fast delay. The code is 2'b10 from the test start to the 1st rise, 2'b01 from the 1st rise to the 7th rise, 2'b10 again from the 7th rise to the 8th fall, and 2'b00 afterwards.
- R8: The clock count saturates. Clocks past the 9th leave the chain-phase behaviour unchanged: `clkOut` keeps following, the enables stay off and `delaySel` stays 2'b00.
- R9: Each output change appears on the third system-clock rising edge after the input change that causes it: two synchronizer stages and then one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| testStartN | input | 1 | Test start, active low; high holds the idle state |
| testClkIn | input | 1 | Slow external test clock |
| activeIn | input | 1 | Active flag from the device above |
| resetOut | output | 1 | Test start passed to the next device (active low) |
| clkOut | output | 1 | Test clock passed to the next device |
| activeOut | output | 1 | Active flag passed down the chain |
| cellCurEn | output | 5 | One-hot enables for the cell test currents |
| delaySel | output | 2 | Detection-delay select for the overcharge timer |

## Verification
Every output is due on the third system-clock rising edge after the pin that causes it changes. The bench measures this directly: it moves the test clock in the chain phase and samples `clkOut` just after the second and third edges. For the stepped sequence, each test-clock phase is held for eight system clocks before sampling, well past the three-edge latency, so the results never depend on sampling right at the boundary. Inputs change on the falling edge, and outputs are read shortly after the rising edge.

// File: rtl/stseq_pkg.sv
package stseq_pkg;

  // Test clock at which reset and clock are handed to the next device.
  localparam int HANDOFF_CLK = 9;
  localparam int CNT_W = $clog2(HANDOFF_CLK + 1);

  typedef enum logic [1:0] {
    DLY_NORMAL = 2'b00,
    DLY_FAST8  = 2'b01,
    DLY_FAST32 = 2'b10
  } dly_sel_e;

  typedef struct packed {
    logic             idle;
    logic             clkLvl;
    logic             caoSet;
    logic             caoClr;
    logic             chainNext;
    logic [CNT_W-1:0] countNext;
  } ctrl_strobe_t;

endpackage

// File: rtl/stseq_sync.sv
module stseq_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= RST_VAL;
    else        stage[0] <= asyncIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= RST_VAL;
        else        stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/stseq_ctrl.sv
module stseq_ctrl
  import stseq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startLvl,
  input  logic         clkLvl,
  input  logic         actLvl,
  output ctrl_strobe_t strobe
);

  localparam logic [CNT_W-1:0] SAT_CNT   = CNT_W'(HANDOFF_CLK);
  localparam logic [CNT_W-1:0] LAST_OWN  = CNT_W'(HANDOFF_CLK - 1);

  logic [CNT_W-1:0] count;
  logic             chainPhase;
  logic             clkPrev;
  logic             clkRise, clkFall;
  logic             idle;
  logic [CNT_W-1:0] countNext;
  logic             chainNext;

  always_comb begin
    idle      = startLvl;
    clkRise   = clkLvl & ~clkPrev;
    clkFall   = ~clkLvl & clkPrev;
    countNext = count;
    if (idle)                             countNext = '0;
    else if (clkRise && count < SAT_CNT)  countNext = count + 1'b1;
    chainNext = ~idle & (chainPhase | (clkFall && count == LAST_OWN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      chainPhase <= 1'b0;
      clkPrev    <= 1'b0;
    end else begin
      count      <= countNext;
      chainPhase <= chainNext;
      clkPrev    <= clkLvl;
    end
  end

  always_comb begin
    strobe.idle      = idle;
    strobe.clkLvl    = clkLvl;
    strobe.chainNext = chainNext;
    strobe.countNext = countNext;
    strobe.caoSet    = ~idle & clkRise &
                       (chainPhase ? actLvl : (count == '0));
    strobe.caoClr    = idle |
                       (chainPhase ? ~actLvl : (clkFall && count == LAST_OWN));
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= SAT_CNT);  // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> (count == '0 || count == $past(count) + 1'b1));  // R8

  AST_CHAIN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    chainPhase |=> (chainPhase || $past(idle)));  // R2

  AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.caoSet && strobe.caoClr));  // R5

endmodule

// File: rtl/stseq_dpath.sv
module stseq_dpath
  import stseq_pkg::*;
#(
  parameter int NUM_CUR_EN     = 5,
  parameter int FAST8_LAST_CLK = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrl_strobe_t          strobe,
  output logic                  resetOut,
  output logic                  clkOut,
  output logic                  activeOut,
  output logic [NUM_CUR_EN-1:0] cellCurEn,
  output dly_sel_e              delaySel
);

  logic [NUM_CUR_EN-1:0] enNext;
  dly_sel_e              dlyNext;

  generate
    for (genvar i = 0; i < NUM_CUR_EN; i++) begin : g_en
      assign enNext[i] = ~strobe.idle & strobe.clkLvl &
                         (strobe.countNext == CNT_W'(i + 1));
    end
  endgenerate

  always_comb begin
    if (strobe.idle || strobe.chainNext)
      dlyNext = DLY_NORMAL;
    else if (strobe.countNext >= CNT_W'(1) && strobe.countNext <= CNT_W'(FAST8_LAST_CLK))
      dlyNext = DLY_FAST8;
    else
      dlyNext = DLY_FAST32;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resetOut  <= 1'b1;
      clkOut    <= 1'b1;
      activeOut <= 1'b0;
      cellCurEn <= '0;
      delaySel  <= DLY_NORMAL;
    end else if (strobe.idle) begin
      resetOut  <= 1'b1;
      clkOut    <= 1'b1;
      activeOut <= 1'b0;
      cellCurEn <= '0;
      delaySel  <= DLY_NORMAL;
    end else begin
      resetOut  <= ~strobe.chainNext;
      clkOut    <= strobe.chainNext & strobe.clkLvl;
      if (strobe.caoClr)      activeOut <= 1'b0;
      else if (strobe.caoSet) activeOut <= 1'b1;
      cellCurEn <= enNext;
      delaySel  <= dlyNext;
    end
  end

  AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cellCurEn));  // R6

  AST_IDLE_OUTS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.idle |=> (resetOut && clkOut && !activeOut && cellCurEn == '0));  // R1

  AST_EN_IN_FAST8: assert property (@(posedge clk) disable iff (!rst_n)
    (cellCurEn != '0) |-> (delaySel == DLY_FAST8));  // R7

  AST_HANDOFF_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    !resetOut |-> (delaySel == DLY_NORMAL && cellCurEn == '0));  // R2

  AST_CLKOUT_AFTER_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (resetOut && !$past(strobe.idle) && !strobe.idle) |-> !clkOut);  // R3

endmodule

// File: rtl/stseq_top.sv
module stseq_top
  import stseq_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int NUM_CUR_EN     = 5,
  parameter int FAST8_LAST_CLK = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  testStartN,
  input  logic                  testClkIn,
  input  logic                  activeIn,
  output logic                  resetOut,
  output logic                  clkOut,
  output logic                  activeOut,
  output logic [NUM_CUR_EN-1:0] cellCurEn,
  output logic [1:0]            delaySel
);

  logic [2:0]   syncLvl;
  ctrl_strobe_t strobe;
  dly_sel_e     dlySel;

  stseq_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b001)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .asyncIn({activeIn, testClkIn, testStartN}),
    .syncOut(syncLvl)
  );

  stseq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .startLvl(syncLvl[0]),
    .clkLvl  (syncLvl[1]),
    .actLvl  (syncLvl[2]),
    .strobe  (strobe)
  );

  stseq_dpath #(
    .NUM_CUR_EN    (NUM_CUR_EN),
    .FAST8_LAST_CLK(FAST8_LAST_CLK)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .resetOut (resetOut),
    .clkOut   (clkOut),
    .activeOut(activeOut),
    .cellCurEn(cellCurEn),
    .delaySel (dlySel)
  );

  assign delaySel = dlySel;

endmodule

// File: tb/stseq_top_test.sv
module stseq_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       testStartN = 1'b1;
  logic       testClkIn = 1'b0;
  logic       activeIn = 1'b0;
  logic       resetOut, clkOut, activeOut;
  logic [4:0] cellCurEn;
  logic [1:0] delaySel;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  stseq_top uut (
    .clk(clk), .rst_n(rst_n), .testStartN(testStartN), .testClkIn(testClkIn),
    .activeIn(activeIn), .resetOut(resetOut), .clkOut(clkOut),
    .activeOut(activeOut), .cellCurEn(cellCurEn), .delaySel(delaySel)
  );

  // {clkLvl, activeIn, expReset, expClkOut, expActive, expEn[4:0], expDly[1:0]}
  localparam int NV = 26;
  localparam logic [11:0] VEC [NV] = '{
    12'b1_0_1_0_1_00001_01,  // clk1 high  R6 R4 R7
    12'b0_0_1_0_1_00000_01,  // clk1 low
    12'b1_0_1_0_1_00010_01,  // clk2 high
    12'b0_0_1_0_1_00000_01,
    12'b1_0_1_0_1_00100_01,  // clk3
    12'b0_1_1_0_1_00000_01,  // activeIn high ignored R4
    12'b1_1_1_0_1_01000_01,  // clk4
    12'b0_0_1_0_1_00000_01,  // activeIn low ignored R4
    12'b1_0_1_0_1_10000_01,  // clk5
    12'b0_0_1_0_1_00000_01,
    12'b1_0_1_0_1_00000_01,  // clk6
    12'b0_0_1_0_1_00000_01,
    12'b1_0_1_0_1_00000_10,  // clk7 -> 32ms window R7
    12'b0_0_1_0_1_00000_10,
    12'b1_0_1_0_1_00000_10,  // clk8 high: reset still high R2
    12'b0_0_0_0_0_00000_00,  // clk8 fall: handoff R2 R4 R7
    12'b1_0_0_1_0_00000_00,  // clk9 high: clkOut follows R3
    12'b0_0_0_0_0_00000_00,
    12'b0_1_0_0_0_00000_00,  // activeIn high between rises: no set R5
    12'b1_1_0_1_1_00000_00,  // clk10 rise with activeIn high R5
    12'b0_1_0_0_1_00000_00,
    12'b0_0_0_0_0_00000_00,  // activeIn low clears R5
    12'b1_0_0_1_0_00000_00,  // clk11 saturation R8
    12'b0_0_0_0_0_00000_00,
    12'b1_1_0_1_1_00000_00,  // clk12 R8 R5
    12'b0_1_0_0_1_00000_00
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic checkAll(input string req, input logic [9:0] exp);
    chk(req, {resetOut, clkOut, activeOut, cellCurEn, delaySel}, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog got=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    waitCycles(3);
    checkAll("R1 under rst_n", 10'b1_1_0_00000_00);
    rst_n = 1'b1;
    waitCycles(5);
    checkAll("R1 idle after reset", 10'b1_1_0_00000_00);

    // start test
    @(negedge clk); testStartN = 1'b0;
    waitCycles(8);
    checkAll("R3 R7 test start", 10'b1_0_0_00000_10);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      testClkIn = VEC[v][11];
      activeIn  = VEC[v][10];
      waitCycles(8);
      checkAll($sformatf("R2-vec%0d", v), VEC[v][9:0]);
    end

    // R9 latency: clkOut follows a rise on the third edge
    @(negedge clk); testClkIn = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 before third edge", clkOut, 0);
    @(posedge clk); #1;
    chk("R9 on third edge", clkOut, 1);
    waitCycles(4);

    // R1 return to idle in chain phase, also with latency R9
    @(negedge clk); testStartN = 1'b1; testClkIn = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    chk("R9 idle not yet", resetOut, 0);
    @(posedge clk); #1;
    checkAll("R1 idle on third edge", 10'b1_1_0_00000_00);
    @(negedge clk); activeIn = 1'b0;

    // restart and abort during clock 3 high
    @(negedge clk); testStartN = 1'b0;
    waitCycles(8);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk); testClkIn = 1'b1; waitCycles(8);
      if (k < 3) begin @(negedge clk); testClkIn = 1'b0; waitCycles(8); end
    end
    checkAll("R6 restart clk3", 10'b1_0_1_00100_01);
    @(negedge clk); testStartN = 1'b1;
    waitCycles(6);
    checkAll("R1 abort mid-test", 10'b1_1_0_00000_00);
    @(negedge clk); testClkIn = 1'b0;
    waitCycles(6);
    checkAll("R1 clock ignored in idle", 10'b1_1_0_00000_00);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule